// File: doc/BRIEF.md
# SAR converter control logic

This block holds the digital sequencing of a 16-bit successive-approximation converter. It runs on an internal clock. An acquisition phase is ended by a falling convert-start while chip-select is held low. A conversion phase of fixed length follows. At the end of that phase the result word, supplied by a stub standing in for the comparator and capacitor array, is latched. The block decides when sampling restarts. It also aborts a running conversion when asked, either through the reset pin or through a control-edge pattern.

Reads go through an output bus with a per-bit enable, driven only while chip-select and read are both low. A byte-select input lets an 8-bit host fetch the word in two halves over the upper bus pins. All control inputs are asynchronous to the internal clock. Each passes through a two-flop synchronizer, so every input change takes effect a fixed number of clock cycles later.

Top module: `sarConvCtrl`

## Requirements
- R1: While reset is low, and after it is released, busy is low, the output latch holds 0000, and sampling is high.
- R2: A convert-start falling edge (input driven low between clock edges) with chip-select low and at least ACQ_MIN cycles of sampling raises busy on the third rising clock edge after the input change, and clears sampling.
- R3: An unaborted conversion keeps busy high for exactly CONV_CYCLES (default 26) cycles.
- R4: A convert-start falling edge while chip-select is high has no effect: busy stays low and sampling stays high.
- R5: A convert-start falling edge that arrives before ACQ_MIN (default 6) sampling cycles have passed is ignored.
- R6: The bus enable is all ones exactly when the synchronized chip-select and read are both low; otherwise the enable is all zeros and the bus value is 0000.
- R7: With byte-select low the bus carries the latched word unchanged, so codes such as 7FFF, 8000, FFFF and 0000 pass through bit for bit. With byte-select high, bus bits 15..8 carry result bits 7..0 and bus bits 7..0 are all ones.
- R8: While busy is high a read returns the previous result; the new result is readable from the cycle in which busy falls.
- R9: A convert-start falling edge with chip-select low, acted on once the conversion counter has reached ABORT_SETUP (default 3), ends busy at once, clears the latch to 0000 and restarts sampling.
- R10: A chip-select falling edge acted on once the conversion counter has reached ABORT_SETUP has the same effect as R9.
- R11: A control edge acted on while the conversion counter is still below ABORT_SETUP is ignored, and the conversion runs its full length.
- R12: If chip-select is low when a conversion ends, sampling rises in the cycle busy falls. If chip-select is high at that point, sampling stays low until a chip-select falling edge.
- R13: Asserting reset during a conversion drops busy without waiting for a clock edge, and leaves the latch at 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rstN | input | 1 | Asynchronous active-low reset, released synchronously inside |
| convStartN | input | 1 | Active-low convert start |
| chipSelN | input | 1 | Active-low chip select |
| readN | input | 1 | Active-low read strobe |
| byteSel | input | 1 | High: low result byte on upper bus pins |
| convWord | input | 16 | Conversion result from the array stub, two's complement |
| busy | output | 1 | High while a conversion runs |
| sampling | output | 1 | High while the input is being acquired |
| busOut | output | 16 | Output bus value |
| busOe | output | 16 | Per-bit output enable for the bus |

## Verification
The assertions assume that every control input holds each level for at least one full clock period, so the synchronizers never drop a pulse. They also assume that reset is driven low at time zero. The bench changes inputs only on falling clock edges, holds convert-start low for two cycles, and keeps chip-select high for several cycles before lowering it. Between conversions it leaves well over ACQ_MIN idle cycles, except in the deliberate early-start and early-abort cases.

// File: rtl/sarPkg.sv
package sarPkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } sarState_t;

  // strobes from the sequencer to the result datapath
  typedef struct packed {
    logic loadResult;
    logic clearResult;
  } sarStrobe_t;
endpackage

// File: rtl/sarSync.sv
module sarSync #(
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RESET_VAL[b];
        stage2 <= RESET_VAL[b];
      end else begin
        stage1 <= asyncIn[b];
        stage2 <= stage1;
      end
    end
    assign syncOut[b] = stage2;
  end
endmodule

// File: rtl/sarControl.sv
module sarControl
  import sarPkg::*;
#(
  parameter int CONV_CYCLES = 26,
  parameter int ACQ_MIN     = 6,
  parameter int ABORT_SETUP = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       convN,
  input  logic       csN,
  output logic       busy,
  output logic       sampling,
  output sarStrobe_t strobe
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam int ACQ_W = $clog2(ACQ_MIN + 1) > 0 ? $clog2(ACQ_MIN + 1) : 1;
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] ABORT_LIM = CNT_W'(ABORT_SETUP);
  localparam logic [ACQ_W-1:0] ACQ_LIM   = ACQ_W'(ACQ_MIN);

  sarState_t st, stNext;
  logic [CNT_W-1:0] convCnt;
  logic [ACQ_W-1:0] acqCnt;
  logic convPrev, csPrev;
  logic convFall, csFall, acqDone, abortReq;

  assign convFall = convPrev & ~convN;
  assign csFall   = csPrev & ~csN;
  assign acqDone  = acqCnt >= ACQ_LIM;
  assign abortReq = (convCnt >= ABORT_LIM) && ((convFall && !csN) || csFall);

  always_comb begin
    stNext = st;
    strobe = '0;
    unique case (st)
      ST_IDLE:   if (csFall) stNext = ST_SAMPLE;
      ST_SAMPLE: if (convFall && !csN && acqDone) stNext = ST_CONV;
      ST_CONV: begin
        if (abortReq) begin
          stNext             = ST_SAMPLE;
          strobe.clearResult = 1'b1;
        end else if (convCnt == CONV_LAST) begin
          strobe.loadResult = 1'b1;
          stNext            = csN ? ST_IDLE : ST_SAMPLE;
        end
      end
      default: stNext = ST_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_SAMPLE;
      convCnt  <= '0;
      acqCnt   <= '0;
      convPrev <= 1'b1;
      csPrev   <= 1'b1;
    end else begin
      st       <= stNext;
      convPrev <= convN;
      csPrev   <= csN;
      convCnt  <= (st == ST_CONV && stNext == ST_CONV) ? convCnt + 1'b1 : '0;
      if (st == ST_SAMPLE && stNext == ST_SAMPLE) begin
        if (!acqDone) acqCnt <= acqCnt + 1'b1;
      end else begin
        acqCnt <= '0;
      end
    end
  end

  assign busy     = (st == ST_CONV);
  assign sampling = (st == ST_SAMPLE);
endmodule

// File: rtl/sarDatapath.sv
module sarDatapath
  import sarPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strobe,
  input  logic [WIDTH-1:0] convWord,
  input  logic             csN,
  input  logic             rdN,
  input  logic             byteSel,
  output logic [WIDTH-1:0] busOut,
  output logic [WIDTH-1:0] busOe
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] resultReg, folded, selected;
  logic drive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    resultReg <= '0;
    else if (strobe.clearResult)  resultReg <= '0;
    else if (strobe.loadResult)   resultReg <= convWord;
  end

  assign folded   = {resultReg[HALF-1:0], {(WIDTH-HALF){1'b1}}};
  assign selected = byteSel ? folded : resultReg;
  assign drive    = !csN && !rdN;
  assign busOe    = {WIDTH{drive}};
  assign busOut   = drive ? selected : '0;
endmodule

// File: rtl/sarConvCtrl.sv
module sarConvCtrl
  import sarPkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 26,
  parameter int ACQ_MIN     = 6,
  parameter int ABORT_SETUP = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             convStartN,
  input  logic             chipSelN,
  input  logic             readN,
  input  logic             byteSel,
  input  logic [WIDTH-1:0] convWord,
  output logic             busy,
  output logic             sampling,
  output logic [WIDTH-1:0] busOut,
  output logic [WIDTH-1:0] busOe
);
  logic [1:0] rstPipe;
  logic intRstN;
  logic [3:0] ctlSync;
  sarStrobe_t strobe;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPipe <= '0;
    else       rstPipe <= {rstPipe[0], 1'b1};
  end
  assign intRstN = rstPipe[1];

  sarSync #(.WIDTH(4), .RESET_VAL(4'b1110)) uSync (
    .clk(clk), .rstN(intRstN),
    .asyncIn({convStartN, chipSelN, readN, byteSel}),
    .syncOut(ctlSync)
  );

  sarControl #(
    .CONV_CYCLES(CONV_CYCLES), .ACQ_MIN(ACQ_MIN), .ABORT_SETUP(ABORT_SETUP)
  ) uCtrl (
    .clk(clk), .rstN(intRstN), .convN(ctlSync[3]), .csN(ctlSync[2]),
    .busy(busy), .sampling(sampling), .strobe(strobe)
  );

  sarDatapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(intRstN), .strobe(strobe), .convWord(convWord),
    .csN(ctlSync[2]), .rdN(ctlSync[1]), .byteSel(ctlSync[0]),
    .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/sarCtrlChecker.sv
module sarCtrlChecker #(
  parameter int WIDTH       = 16,
  parameter int CONV_CYCLES = 26
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             sampling,
  input logic [WIDTH-1:0] busOut,
  input logic [WIDTH-1:0] busOe
);
  logic [15:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runCnt <= '0;
    else if (busy) runCnt <= runCnt + 16'd1;
    else           runCnt <= '0;
  end

  // R3: no busy period outlasts the conversion length
  a_r3_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (runCnt < 16'(CONV_CYCLES)));

  // R6: the enable is all-or-nothing
  a_r6_oe_uniform: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(busOe) == 0) || ($countones(busOe) == WIDTH));

  // R6: an undriven bus carries zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busOe == '0) |-> (busOut == '0));

  // R12: sampling and converting never overlap
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && sampling));

  // R2: a conversion only begins out of sampling
  a_r2_from_sample: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(sampling));
endmodule

bind sarConvCtrl sarCtrlChecker #(.WIDTH(WIDTH), .CONV_CYCLES(CONV_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .sampling(sampling),
  .busOut(busOut), .busOe(busOe)
);

// File: tb/sarConvCtrl_test.sv
module sarConvCtrl_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, convStartN, chipSelN, readN, byteSel;
  logic [15:0] convWord;
  logic busy, sampling;
  logic [15:0] busOut, busOe;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  sarConvCtrl uut (
    .clk(clk), .rstN(rstN), .convStartN(convStartN), .chipSelN(chipSelN),
    .readN(readN), .byteSel(byteSel), .convWord(convWord),
    .busy(busy), .sampling(sampling), .busOut(busOut), .busOe(busOe)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expBus(logic [15:0] w, bit bsel);
    return bsel ? {w[7:0], 8'hFF} : w;
  endfunction

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // drives convert-start low at N0; indices count later falling clock edges
  task automatic runConv(input logic [15:0] word, input logic [15:0] prevWord,
                         input int convLowAt, input int csHighAt, input int csLowAt,
                         input bit checkHold,
                         output int firstBusy, output int len, output bit sampAtFall,
                         output logic [15:0] busAtFall, output bit holdOk);
    bit fallSeen = 0;
    convWord = word;
    @(negedge clk);
    convStartN = 1'b0;
    firstBusy = -1; len = 0; holdOk = 1; sampAtFall = 0; busAtFall = '0;
    for (int i = 1; i <= 45; i++) begin
      @(negedge clk);
      if (busy) begin
        if (firstBusy < 0) firstBusy = i;
        len++;
        if (checkHold && busOut !== prevWord) holdOk = 0;
      end else if (firstBusy >= 0 && !fallSeen) begin
        fallSeen   = 1;
        sampAtFall = sampling;
        busAtFall  = busOut;
      end
      if (i == 2) convStartN = 1'b1;
      if (i == convLowAt) convStartN = 1'b0;
      if (i == convLowAt + 2) convStartN = 1'b1;
      if (i == csHighAt) chipSelN = 1'b1;
      if (i == csLowAt) chipSelN = 1'b0;
    end
    convStartN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int fb, ln;
    bit sf, hok, anyBusy;
    logic [15:0] ba, w, prev;
    bit b;
    rstN = 1'b0; convStartN = 1'b1; chipSelN = 1'b0; readN = 1'b0;
    byteSel = 1'b0; convWord = '0;
    void'($urandom(32'h5EED));
    waitN(3);
    check(busy == 1'b0, "R1 busy in reset", 32'(busy), 0);
    check(busOut == 16'h0, "R1 bus in reset", 32'(busOut), 0);
    rstN = 1'b1;
    waitN(12);
    check(busy == 1'b0 && sampling == 1'b1, "R1 idle after release", {busy, sampling}, 32'h1);
    check(busOut == 16'h0, "R1 latch cleared", 32'(busOut), 0);

    // R2 R3 R8 R12 basic conversion
    runConv(16'h7FFF, 16'h0000, -10, -10, -10, 1, fb, ln, sf, ba, hok);
    check(fb == 3, "R2 busy rise latency", 32'(fb), 3);
    check(ln == 26, "R3 busy length", 32'(ln), 26);
    check(hok, "R8 old data during busy", 32'(hok), 1);
    check(ba == 16'h7FFF, "R8 new data at busy fall", 32'(ba), 32'h7FFF);
    check(sf == 1'b1, "R12 sampling at busy fall", 32'(sf), 1);
    prev = 16'h7FFF;
    byteSel = 1'b1; waitN(3);
    check(busOut == expBus(prev, 1), "R7 fold", 32'(busOut), 32'(expBus(prev, 1)));
    byteSel = 1'b0; waitN(10);

    // R7 R3 random and directed words
    for (int k = 0; k < 14; k++) begin
      w = (k == 0) ? 16'h8000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h0000 : 16'($urandom);
      b = 1'($urandom % 2);
      runConv(w, prev, -10, -10, -10, 1, fb, ln, sf, ba, hok);
      check(ln == 26 && hok, "R3 length and hold", 32'(ln), 26);
      byteSel = b; waitN(3);
      check(busOut == expBus(w, b), "R7 readout", 32'(busOut), 32'(expBus(w, b)));
      check(busOe == 16'hFFFF, "R6 enable on", 32'(busOe), 32'hFFFF);
      byteSel = 1'b0; prev = w; waitN(10);
    end

    // R6 bus disable combinations
    readN = 1'b1; waitN(3);
    check(busOe == 16'h0 && busOut == 16'h0, "R6 read high", 32'(busOe), 0);
    readN = 1'b0; chipSelN = 1'b1; waitN(3);
    check(busOe == 16'h0 && busOut == 16'h0, "R6 cs high", 32'(busOe), 0);

    // R4 convert start with chip-select high
    convStartN = 1'b0; waitN(2); convStartN = 1'b1;
    anyBusy = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (busy) anyBusy = 1; end
    check(!anyBusy && sampling, "R4 ignored with cs high", {anyBusy, sampling}, 32'h1);
    chipSelN = 1'b0; waitN(10);
    check(busOe == 16'hFFFF && busOut == prev, "R6 enable restored", 32'(busOut), 32'(prev));

    // R5 restart right after end of conversion
    runConv(16'h1357, prev, 29, -10, -10, 1, fb, ln, sf, ba, hok);
    check(ln == 26, "R5 early start ignored", 32'(ln), 26);
    check(sampling == 1'b1, "R5 still sampling", 32'(sampling), 1);
    prev = 16'h1357; waitN(10);

    // R11 early abort edge ignored
    runConv(16'h2468, prev, 3, -10, -10, 1, fb, ln, sf, ba, hok);
    check(ln == 26, "R11 early edge ignored", 32'(ln), 26);
    check(ba == 16'h2468, "R11 result latched", 32'(ba), 32'h2468);
    prev = 16'h2468; waitN(10);

    // R9 abort via convert start
    runConv(16'h5678, prev, 8, -10, -10, 0, fb, ln, sf, ba, hok);
    check(ln == 8, "R9 busy cut short", 32'(ln), 8);
    check(ba == 16'h0000, "R9 latch cleared", 32'(ba), 0);
    check(sf == 1'b1, "R9 sampling resumes", 32'(sf), 1);
    waitN(10);
    runConv(16'h4321, 16'h0000, -10, -10, -10, 1, fb, ln, sf, ba, hok);
    waitN(10);

    // R10 abort via chip-select falling edge
    runConv(16'h9ABC, 16'h4321, -10, 4, 8, 0, fb, ln, sf, ba, hok);
    check(ln == 8, "R10 busy cut short", 32'(ln), 8);
    check(ba == 16'h0000, "R10 latch cleared", 32'(ba), 0);
    check(sf == 1'b1, "R10 sampling resumes", 32'(sf), 1);
    waitN(10);

    // R12 chip-select high at end of conversion
    runConv(16'hC0DE, 16'h0000, -10, 4, -10, 0, fb, ln, sf, ba, hok);
    check(ln == 26, "R12 full length", 32'(ln), 26);
    check(sf == 1'b0 && sampling == 1'b0, "R12 waits for cs", {sf, sampling}, 0);
    chipSelN = 1'b0; waitN(4);
    check(sampling == 1'b1, "R12 sampling after cs fall", 32'(sampling), 1);
    check(busOut == 16'hC0DE, "R8 result kept", 32'(busOut), 32'hC0DE);
    waitN(10);

    // R13 reset during a conversion
    convWord = 16'h7777;
    convStartN = 1'b0; waitN(2); convStartN = 1'b1; waitN(8);
    check(busy == 1'b1, "R13 converting", 32'(busy), 1);
    #1 rstN = 1'b0;
    #0.5;
    check(busy == 1'b0, "R13 busy drops at once", 32'(busy), 0);
    waitN(2); rstN = 1'b1; waitN(12);
    check(busy == 1'b0 && sampling == 1'b1, "R13 sampling after reset", {busy, sampling}, 32'h1);
    check(busOut == 16'h0, "R13 latch cleared", 32'(busOut), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule